// File: doc/BRIEF.md
# Machine-Cycle Clock Sequencer with Optional Half-Rate Divider

This block derives the processor core timing from the oscillator clock. Nothing is gated. The block produces a core clock enable. In standard mode the enable is high on every second oscillator edge, which acts as a divide-by-two stage. In double-speed mode the divider is bypassed and the enable is high on every edge. A mode bit from the clock control register selects between the two modes. That bit is resynchronised so that it only takes effect when the divided clock rises. As a result, a switch in either direction never shortens a core clock phase.

On every core enable, a sequencer steps through the six states of a machine cycle. Two external-memory strobes are decoded from the state. The address-latch strobe pulses twice per machine cycle. The program-fetch strobe also pulses twice per cycle, but only in cycles that fetch code. A data-access flag marks the cycles that access external data memory. It is sampled when a machine cycle begins. In a flagged cycle the second address-latch pulse and both fetch pulses are withheld. The asynchronous active-low reset is released through a synchroniser.

Top module: `clkseq_top`

## Requirements
- R1: While reset is held, and until the first enabled step after its release, the state index is 1, standard mode is selected, and core_ce, ale and psen are all low.
- R2: In standard mode core_ce is never high on two consecutive oscillator cycles. Over 24 cycles it is high exactly 12 times, giving 12 oscillator cycles per machine cycle.
- R3: In double-speed mode core_ce is high on every oscillator cycle, giving 6 oscillator cycles per machine cycle.
- R4: A new value on x2_req is taken into the active mode only at an oscillator edge where the divided clock rises, meaning the divider phase is low before that edge. Changes at other times have no effect until such an edge.
- R5: state_idx takes values 1 to 6. It advances by one on each edge at which core_ce is high, wraps from 6 to 1, and holds otherwise.
- R6: In a code cycle, ale is high exactly while the state is 1 or 4, which gives two rising ale edges per machine cycle.
- R7: In a code cycle, psen is high exactly while the state is 2, 3, 5 or 6, which gives two rising psen edges per machine cycle. ale and psen are never high together.
- R8: data_req is sampled at the enabled edge that moves the state from 6 to 1. When the sampled value is 1, that machine cycle keeps the ale pulse of state 1, drops the ale pulse of state 4, and holds psen low throughout.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_osc | input | 1 | Oscillator clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| x2_req | input | 1 | Clock control bit 0: 1 requests double-speed mode |
| data_req | input | 1 | 1 marks the next machine cycle as an external data access |
| core_ce | output | 1 | Core clock enable for the next oscillator edge |
| state_idx | output | 3 | Current machine-cycle state, 1 to 6 |
| ale | output | 1 | Address latch strobe, registered |
| psen | output | 1 | Program fetch strobe, registered |

## Verification
The bench toggles x2_req while the divider phase is high. A design that sampled the bit on every edge would then give two enables in a row, or a half-length core phase, at the moment of the switch. It moves data_req within a machine cycle to catch a design that samples the flag at any point other than the wrap from state 6 to 1; such a design would cut off or add fetch pulses partway through a cycle. It counts strobe edges over whole machine cycles in both modes and for both cycle kinds. A wrong decode or a missing suppression then shows up as an extra or missing pulse. A reset asserted partway through the run checks that the sequencer returns to state 1 and the strobes go quiet.

// File: rtl/clkseq_pkg.sv
package clkseq_pkg;
  typedef struct packed {
    logic ale;
    logic psen;
  } strobe_t;
endpackage

// File: rtl/clkseq_rst_sync.sv
module clkseq_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_n_sync
);
  logic [STAGES-1:0] chain_q;
  logic [STAGES-1:0] chain_nx;

  always_comb chain_nx = {chain_q[STAGES-2:0], 1'b1};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) chain_q <= '0;
    else        chain_q <= chain_nx;
  end

  assign rst_n_sync = chain_q[STAGES-1];
endmodule

// File: rtl/clkseq_div.sv
module clkseq_div (
  input  logic clk,
  input  logic rst_n,
  input  logic x2_req,
  output logic core_ce,
  output logic mode_x2,
  output logic div_ph
);
  logic div_q, div_nx;
  logic mode_q, mode_nx;

  // The divided clock rises at an edge where div_q is low beforehand; only there is the mode bit captured.
  always_comb begin
    div_nx  = ~div_q;
    mode_nx = div_q ? mode_q : x2_req;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      div_q  <= 1'b0;
      mode_q <= 1'b0;
    end else begin
      div_q  <= div_nx;
      mode_q <= mode_nx;
    end
  end

  assign core_ce = mode_q | div_q;
  assign mode_x2 = mode_q;
  assign div_ph  = div_q;
endmodule

// File: rtl/clkseq_seq.sv
module clkseq_seq #(
  parameter int NUM_STATES = 6,
  parameter int SW = 3
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          core_ce,
  input  logic          data_req,
  output logic [SW-1:0] st_cur,
  output logic [SW-1:0] st_next,
  output logic          dac_next
);
  localparam logic [SW-1:0] FIRST = SW'(1);
  localparam logic [SW-1:0] LAST  = SW'(NUM_STATES);

  logic [SW-1:0] st_q, st_nx;
  logic          dac_q, dac_nx;
  logic          wrap;

  always_comb begin
    wrap   = core_ce && (st_q == LAST);
    st_nx  = st_q;
    dac_nx = dac_q;
    if (core_ce) st_nx = wrap ? FIRST : st_q + FIRST;
    if (wrap)    dac_nx = data_req;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q  <= FIRST;
      dac_q <= 1'b0;
    end else begin
      st_q  <= st_nx;
      dac_q <= dac_nx;
    end
  end

  assign st_cur   = st_q;
  assign st_next  = st_nx;
  assign dac_next = dac_nx;
endmodule

// File: rtl/clkseq_strobe.sv
module clkseq_strobe
  import clkseq_pkg::*;
#(
  parameter int NUM_STATES = 6,
  parameter int SW = 3
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [SW-1:0] st_next,
  input  logic          dac_next,
  output strobe_t       strb
);
  localparam int HALF  = NUM_STATES / 2;
  localparam int SLOTS = 2 ** SW;

  logic [SLOTS-1:0] ale_mask;
  logic [SLOTS-1:0] psen_mask;
  logic [SLOTS-1:0] first_mask;

  for (genvar s = 0; s < SLOTS; s++) begin : g_mask
    assign ale_mask[s]   = (s == 1) || (s == HALF + 1);
    assign first_mask[s] = (s == 1);
    assign psen_mask[s]  = ((s >= 2) && (s <= HALF)) ||
                           ((s >= HALF + 2) && (s <= NUM_STATES));
  end

  strobe_t strb_q, strb_nx;

  always_comb begin
    strb_nx.ale  = ale_mask[st_next] && (first_mask[st_next] || !dac_next);
    strb_nx.psen = psen_mask[st_next] && !dac_next;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) strb_q <= '0;
    else        strb_q <= strb_nx;
  end

  assign strb = strb_q;
endmodule

// File: rtl/clkseq_top.sv
module clkseq_top
  import clkseq_pkg::*;
#(
  parameter int NUM_STATES  = 6,
  parameter int SYNC_STAGES = 2,
  localparam int SW = $clog2(NUM_STATES + 1)
) (
  input  logic          clk_osc,
  input  logic          rst_n,
  input  logic          x2_req,
  input  logic          data_req,
  output logic          core_ce,
  output logic [SW-1:0] state_idx,
  output logic          ale,
  output logic          psen
);
  logic          rst_n_i;
  logic          mode_q;
  logic          div_q;
  logic [SW-1:0] st_nx;
  logic          dac_nx;
  strobe_t       strb;

  clkseq_rst_sync #(.STAGES(SYNC_STAGES)) u_rst (
    .clk(clk_osc), .rst_n(rst_n), .rst_n_sync(rst_n_i)
  );

  clkseq_div u_div (
    .clk(clk_osc), .rst_n(rst_n_i), .x2_req(x2_req),
    .core_ce(core_ce), .mode_x2(mode_q), .div_ph(div_q)
  );

  clkseq_seq #(.NUM_STATES(NUM_STATES), .SW(SW)) u_seq (
    .clk(clk_osc), .rst_n(rst_n_i), .core_ce(core_ce), .data_req(data_req),
    .st_cur(state_idx), .st_next(st_nx), .dac_next(dac_nx)
  );

  clkseq_strobe #(.NUM_STATES(NUM_STATES), .SW(SW)) u_strb (
    .clk(clk_osc), .rst_n(rst_n_i), .st_next(st_nx), .dac_next(dac_nx),
    .strb(strb)
  );

  assign ale  = strb.ale;
  assign psen = strb.psen;
endmodule

// File: rtl/clkseq_chk.sv
module clkseq_chk #(
  parameter int NUM_STATES = 6,
  parameter int SW = 3
) (
  input logic          clk,
  input logic          rst_n,
  input logic          core_ce,
  input logic [SW-1:0] state_idx,
  input logic          ale,
  input logic          psen,
  input logic          mode_x2,
  input logic          div_ph
);
  assert_wrap_R5: assert property (@(posedge clk) disable iff (!rst_n)
    core_ce && (state_idx == SW'(NUM_STATES)) |=> state_idx == SW'(1));

  assert_hold_R5: assert property (@(posedge clk) disable iff (!rst_n)
    !core_ce |=> $stable(state_idx));

  assert_range_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (state_idx >= SW'(1)) && (state_idx <= SW'(NUM_STATES)));

  assert_half_rate_R2: assert property (@(posedge clk) disable iff (!rst_n)
    !mode_x2 && core_ce |=> !core_ce);

  assert_mode_edge_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_x2 != $past(mode_x2)) |-> !$past(div_ph));

  assert_excl_R7: assert property (@(posedge clk) disable iff (!rst_n)
    !(ale && psen));
endmodule

bind clkseq_top clkseq_chk #(.NUM_STATES(NUM_STATES), .SW(SW)) u_chk (
  .clk(clk_osc), .rst_n(rst_n), .core_ce(core_ce), .state_idx(state_idx),
  .ale(ale), .psen(psen), .mode_x2(mode_q), .div_ph(div_q)
);

// File: tb/clkseq_top_tb.sv
module clkseq_top_tb;
  localparam int NS = 6;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic x2_req = 1'b0;
  logic data_req = 1'b0;
  logic core_ce, ale, psen;
  logic [2:0] state_idx;

  always #4 clk = ~clk;

  clkseq_top u_dut (
    .clk_osc(clk), .rst_n(rst_n), .x2_req(x2_req), .data_req(data_req),
    .core_ce(core_ce), .state_idx(state_idx), .ale(ale), .psen(psen)
  );

  int checks = 0;
  int errors = 0;
  bit cmp_en = 1'b0;

  int m_div, m_x2, m_st, m_dac, m_sc, m_val;

  function automatic int exp_ale(int st, int dac);
    if (st == 1) return 1;
    if (st == NS/2 + 1 && dac == 0) return 1;
    return 0;
  endfunction

  function automatic int exp_psen(int st, int dac);
    if (dac != 0) return 0;
    if (st >= 2 && st <= NS/2) return 1;
    if (st >= NS/2 + 2 && st <= NS) return 1;
    return 0;
  endfunction

  task automatic chk(string tag, int act, int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d at %0t", tag, act, exp, $time);
    end
  endtask

  // reference model, stepped at every oscillator edge
  always @(posedge clk) begin
    int ce, n_x2;
    if (!rst_n) begin
      m_div = 0; m_x2 = 0; m_st = 1; m_dac = 0; m_sc = 0; m_val = 0;
    end else if (m_sc < 2) begin
      m_sc++;
    end else begin
      ce   = (m_x2 != 0 || m_div != 0) ? 1 : 0;
      n_x2 = (m_div != 0) ? m_x2 : int'(x2_req);
      if (ce != 0) begin
        if (m_st == NS) begin
          m_st = 1;
          m_dac = int'(data_req);
        end else begin
          m_st++;
        end
      end
      m_div = 1 - m_div;
      m_x2  = n_x2;
      m_val = 1;
    end
  end

  always @(negedge clk) begin
    if (rst_n && cmp_en) begin
      chk("R4 core_ce", int'(core_ce), (m_x2 != 0 || m_div != 0) ? 1 : 0);
      chk("R5 state_idx", int'(state_idx), m_st);
      chk("R6 ale", int'(ale), m_val != 0 ? exp_ale(m_st, m_dac) : 0);
      chk("R7 psen", int'(psen), m_val != 0 ? exp_psen(m_st, m_dac) : 0);
      if (m_dac != 0) chk("R8 psen in data cycle", int'(psen), 0);
    end
  end

  task automatic do_reset();
    @(negedge clk);
    cmp_en = 1'b0;
    #1 rst_n = 1'b0;
    repeat (3) @(negedge clk);
    chk("R1 reset core_ce", int'(core_ce), 0);
    chk("R1 reset state_idx", int'(state_idx), 1);
    chk("R1 reset ale", int'(ale), 0);
    chk("R1 reset psen", int'(psen), 0);
    rst_n = 1'b1;
    cmp_en = 1'b1;
    @(negedge clk);
    chk("R1 sync release state_idx", int'(state_idx), 1);
    chk("R1 sync release core_ce", int'(core_ce), 0);
  endtask

  task automatic count_win(int n, output int ce_n, output int ale_r, output int psen_r);
    logic pa, pp;
    ce_n = 0; ale_r = 0; psen_r = 0;
    pa = ale; pp = psen;
    repeat (n) begin
      @(negedge clk);
      if (core_ce) ce_n++;
      if (ale && !pa) ale_r++;
      if (psen && !pp) psen_r++;
      pa = ale; pp = psen;
    end
  endtask

  initial begin
    int c, a, p, seed;
    seed = $urandom(32'h5eed_c10c);
    do_reset();

    // standard mode, code cycles
    repeat (30) @(negedge clk);
    count_win(24, c, a, p);
    chk("R2 enables per 24 osc", c, 12);
    chk("R6 ale rises per 2 cycles std", a, 4);
    chk("R7 psen rises per 2 cycles std", p, 4);

    // switch to double speed
    x2_req = 1'b1;
    repeat (20) @(negedge clk);
    count_win(12, c, a, p);
    chk("R3 enables per 12 osc", c, 12);
    chk("R6 ale rises per 2 cycles x2", a, 4);
    chk("R7 psen rises per 2 cycles x2", p, 4);

    // data cycles in double speed
    data_req = 1'b1;
    repeat (12) @(negedge clk);
    count_win(12, c, a, p);
    chk("R8 ale rises data cycles", a, 2);
    chk("R8 psen rises data cycles", p, 0);
    data_req = 1'b0;

    // mode bit toggled with the divider phase high: back to standard
    repeat (7) @(negedge clk);
    x2_req = 1'b0;
    repeat (20) @(negedge clk);
    count_win(24, c, a, p);
    chk("R2 enables after switch back", c, 12);
    chk("R6 ale rises after switch back", a, 4);

    // short pulse on the mode bit, one cycle wide, at both phases
    for (int k = 0; k < 8; k++) begin
      @(negedge clk);
      x2_req = 1'b1;
      @(negedge clk);
      x2_req = 1'b0;
      repeat (k) @(negedge clk);
    end

    // random phase
    for (int i = 0; i < 4000; i++) begin
      @(negedge clk);
      data_req = ($urandom % 3) == 0;
      if (($urandom % 40) == 0) x2_req = ~x2_req;
    end

    // mid-run reset
    do_reset();
    x2_req = 1'b1;
    for (int i = 0; i < 600; i++) begin
      @(negedge clk);
      data_req = $urandom % 2;
      if (($urandom % 25) == 0) x2_req = ~x2_req;
    end

    @(negedge clk);
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    checks++;
    errors++;
    $display("FAIL watchdog expired");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule